// File: doc/BRIEF.md
# Fused Two-Product Multiply-Add for Quadrature Mixing

This block forms the sum or difference of two products in a single arithmetic unit. It returns A·B + C·D or A·B − C·D. The operands A and C are two's complement samples. B and D are sign-magnitude samples, such as the cosine and sine outputs of a numerically controlled oscillator. A complex multiplier is built from two instances: one wired for A·B − C·D and the other for A·D + C·B.

A control bit selects whether the second product is added or subtracted. Negation never uses its own adder. The control bit flips the sign of D before D is converted from sign-magnitude to two's complement. The conversion itself creates no carry chain: the "+1" it needs appears as one extra partial product. Each product becomes seven partial products. Five are unsigned 11-bit by 2-bit slices. One is the magnitude top-bit row combined with the sign-times-sign term. One gathers the negative components and the increment. All fourteen rows go into a balanced adder tree with a register after every level.

Top module: `bw_dual_mac`

## Requirements
- R1: With `sub` = 0, `y` equals A·B + C·D as a 24-bit two's complement value.
- R2: With `sub` = 1, `y` equals A·B − C·D as a 24-bit two's complement value.
- R3: `a` and `c` are read as two's complement. For `b` and `d`, bit 11 is the sign (1 = negative) and bits 10:0 are the magnitude.
- R4: A sign-magnitude negative zero (bit 11 = 1, magnitude 0) on `b` or `d` acts as zero. This holds for both values of `sub`.
- R5: The extreme operands are exact, with no wrap: `a`/`c` = −2048 and magnitudes of 2047 with either sign. Results reach ±8384512.
- R6: A sample taken with `valid_in` = 1 at a rising edge reaches `y` with `valid_out` = 1 at the fourth rising edge after that one (five registers). A new sample can be accepted on every cycle. `valid_out` copies `valid_in` with the same delay.
- R7: While `rst_n` is low at a rising edge, `valid_out` and `y` become 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operands on this cycle are valid |
| sub | input | 1 | 1 subtracts the second product, 0 adds it |
| a | input | 12 | First two's complement operand |
| b | input | 12 | First sign-magnitude operand |
| c | input | 12 | Second two's complement operand |
| d | input | 12 | Second sign-magnitude operand |
| valid_out | output | 1 | `y` holds a valid result |
| y | output | 24 | Two's complement result |

## Verification
Some rows are hard to reach from the ports. The conversion increment and the negative-component row only matter for particular operand combinations. Negative zero on `d` becomes positive zero when `sub` = 1 flips its sign, and a positive zero becomes negative zero. These sign and magnitude pairings are driven directly, together with −2048 against magnitude 2047, because random operands almost never produce them. A randomized stream with irregular gaps in `valid_in` then fills the pipeline back to back. It checks that every result stays aligned with its own valid flag.

// File: rtl/bw_dual_mac.sv
module bw_dual_mac #(
  parameter int W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic             sub,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     c,
  input  logic [W-1:0]     d,
  output logic             valid_out,
  output logic [2*W-1:0]   y
);
  localparam int MW  = W - 1;
  localparam int OW  = 2 * W;
  localparam int NSL = (W - 2) / 2;
  localparam int NPH = NSL + 2;
  localparam int N0  = 2 * NPH;
  localparam int N1  = (N0 + 1) / 2;
  localparam int N2  = (N1 + 1) / 2;
  localparam int N3  = (N2 + 1) / 2;
  localparam int LAT = 5;

  typedef logic [OW-1:0] word_t;
  typedef word_t [NPH-1:0] ppv_t;

  function automatic word_t zx(input logic [MW-1:0] v);
    return {{(OW-MW){1'b0}}, v};
  endfunction

  function automatic ppv_t gen_pp(input logic [W-1:0] x, input logic [W-1:0] ysm,
                                  input logic flip);
    ppv_t p;
    logic s, xs;
    logic [MW-1:0] bt, xl;
    s  = ysm[W-1] ^ flip;
    bt = ysm[MW-1:0] ^ {MW{s}};
    xl = x[MW-1:0];
    xs = x[W-1];
    for (int k = 0; k < NSL; k++)
      p[k] = (zx(xl) * {{(OW-2){1'b0}}, bt[2*k +: 2]}) << (2*k);
    // top magnitude row plus sign-by-sign term
    p[NSL] = ((bt[MW-1] ? zx(xl) : word_t'(0)) << (MW-1))
           + ({{(OW-1){1'b0}}, xs & s} << (OW-2));
    // negative components and the conversion increment
    p[NSL+1] = ((~zx(xl & {MW{s}}) + 1'b1) << MW)
             + ((~zx(bt & {MW{xs}}) + 1'b1) << MW)
             + (s ? {{(OW-W){x[W-1]}}, x} : word_t'(0));
    return p;
  endfunction

  logic [N0-1:0][OW-1:0] pp_all;
  assign pp_all = {gen_pp(c, d, sub), gen_pp(a, b, 1'b0)};

  logic [LAT-1:0] vpipe;
  word_t s0 [N0];
  word_t s1 [N1];
  word_t s2 [N2];
  word_t s3 [N3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpipe <= '0;
      for (int i = 0; i < N0; i++) s0[i] <= '0;
      for (int i = 0; i < N1; i++) s1[i] <= '0;
      for (int i = 0; i < N2; i++) s2[i] <= '0;
      for (int i = 0; i < N3; i++) s3[i] <= '0;
      y <= '0;
    end else begin
      vpipe <= {vpipe[LAT-2:0], valid_in};
      for (int i = 0; i < N0; i++) s0[i] <= pp_all[i];
      for (int i = 0; i < N1; i++) begin
        if (2*i + 1 < N0) s1[i] <= s0[2*i] + s0[2*i+1];
        else              s1[i] <= s0[2*i];
      end
      for (int i = 0; i < N2; i++) begin
        if (2*i + 1 < N1) s2[i] <= s1[2*i] + s1[2*i+1];
        else              s2[i] <= s1[2*i];
      end
      for (int i = 0; i < N3; i++) begin
        if (2*i + 1 < N2) s3[i] <= s2[2*i] + s2[2*i+1];
        else              s3[i] <= s2[2*i];
      end
      y <= s3[0] + s3[1];
    end
  end

  assign valid_out = vpipe[LAT-1];
endmodule

// File: rtl/bw_dual_mac_chk.sv
module bw_dual_mac_chk #(
  parameter int W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           valid_in,
  input logic           sub,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [W-1:0]   c,
  input logic [W-1:0]   d,
  input logic           valid_out,
  input logic [2*W-1:0] y
);
  localparam int LAT = 5;

  function automatic int smv(input logic [W-1:0] v);
    return v[W-1] ? -int'(v[W-2:0]) : int'(v[W-2:0]);
  endfunction

  int rq [LAT];
  logic [LAT-1:0] vq, zq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vq <= '0;
      zq <= '0;
      for (int i = 0; i < LAT; i++) rq[i] <= 0;
    end else begin
      vq <= {vq[LAT-2:0], valid_in};
      zq <= {zq[LAT-2:0], (b[W-2:0] == '0) && (d[W-2:0] == '0)};
      rq[0] <= sub ? int'($signed(a)) * smv(b) - int'($signed(c)) * smv(d)
                   : int'($signed(a)) * smv(b) + int'($signed(c)) * smv(d);
      for (int i = 1; i < LAT; i++) rq[i] <= rq[i-1];
    end
  end

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out == vq[LAT-1]);

  // R1 R2 R3 R5
  result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vq[LAT-1] |-> (int'($signed(y)) == rq[LAT-1]));

  // R4
  negzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vq[LAT-1] && zq[LAT-1]) |-> (y == '0));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!valid_out && y == '0));
endmodule

bind bw_dual_mac bw_dual_mac_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .sub(sub),
  .a(a), .b(b), .c(c), .d(d), .valid_out(valid_out), .y(y)
);

// File: tb/test_bw_dual_mac.sv
module test_bw_dual_mac;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_in = 1'b0;
  logic sub = 1'b0;
  logic [11:0] a = '0, b = '0, c = '0, d = '0;
  logic valid_out;
  logic [23:0] y;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bw_dual_mac i_bw_dual_mac (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .sub(sub),
    .a(a), .b(b), .c(c), .d(d), .valid_out(valid_out), .y(y)
  );

  function automatic int smd(input logic [11:0] v);
    return v[11] ? -int'(v[10:0]) : int'(v[10:0]);
  endfunction

  function automatic int expect_of(input logic [11:0] ea, input logic [11:0] eb,
                                   input logic [11:0] ec, input logic [11:0] ed,
                                   input logic es);
    int p1, p2;
    p1 = int'($signed(ea)) * smd(eb);
    p2 = int'($signed(ec)) * smd(ed);
    return es ? p1 - p2 : p1 + p2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    valid_in = 1'b1;
    repeat (3) @(negedge clk);
    // R7
    chk("R7 valid_out in reset", int'(valid_out), 0);
    chk("R7 y in reset", int'($signed(y)), 0);
    valid_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_one(input string req, input logic [11:0] ta, input logic [11:0] tb,
                       input logic [11:0] tc, input logic [11:0] td, input logic ts);
    a = ta; b = tb; c = tc; d = td; sub = ts; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    a = '0; b = '0; c = '0; d = '0;
    repeat (3) @(negedge clk);
    // R6: not yet visible one cycle early
    chk("R6 early valid_out", int'(valid_out), 0);
    @(negedge clk);
    chk("R6 valid_out", int'(valid_out), 1);
    chk(req, int'($signed(y)), expect_of(ta, tb, tc, td, ts));
  endtask

  task automatic t_add;
    t_one("R1 add", 12'd100, 12'h003, 12'hFFB, 12'h807, 1'b0);
    t_one("R1 R3 add mixed signs", 12'h9C4, 12'h8FF, 12'd37, 12'h0C8, 1'b0);
  endtask

  task automatic t_sub;
    t_one("R2 sub", 12'd100, 12'h003, 12'hFFB, 12'h807, 1'b1);
    t_one("R2 R3 sub mixed signs", 12'h7D0, 12'h8AB, 12'hF00, 12'h3CD, 1'b1);
  endtask

  task automatic t_negzero;
    t_one("R4 negzero both add", 12'h5A5, 12'h800, 12'hA5A, 12'h800, 1'b0);
    t_one("R4 negzero both sub", 12'h5A5, 12'h800, 12'hA5A, 12'h800, 1'b1);
    t_one("R4 poszero d with sub", 12'h123, 12'h045, 12'h800, 12'h000, 1'b1);
    t_one("R4 negzero d with sub", 12'h123, 12'h845, 12'h7FF, 12'h800, 1'b1);
  endtask

  task automatic t_extremes;
    t_one("R5 max positive", 12'h800, 12'hFFF, 12'h800, 12'hFFF, 1'b0);
    t_one("R5 max negative", 12'h800, 12'h7FF, 12'h800, 12'hFFF, 1'b1);
    t_one("R5 cancel", 12'h800, 12'h7FF, 12'h800, 12'h7FF, 1'b1);
    t_one("R5 positive edge", 12'h7FF, 12'h7FF, 12'h7FF, 12'hFFF, 1'b1);
  endtask

  task automatic t_stream;
    int ex [48];
    logic vx [48];
    for (int k = 0; k < 48; k++) begin
      if (k >= 5) begin
        chk("R6 stream valid", int'(valid_out), int'(vx[k-5]));
        if (vx[k-5]) chk("R1 R2 stream result", int'($signed(y)), ex[k-5]);
      end
      a = 12'($urandom); b = 12'($urandom); c = 12'($urandom); d = 12'($urandom);
      sub = 1'($urandom);
      valid_in = (k < 43) ? (($urandom % 4) != 0) : 1'b0;
      vx[k] = valid_in;
      ex[k] = expect_of(a, b, c, d, sub);
      @(negedge clk);
    end
    valid_in = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_add;
    t_sub;
    t_negzero;
    t_extremes;
    t_stream;
    t_reset;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule